// File: doc/BRIEF.md
# DMA Auto-Align Access Sequencer

This block works out the order of bus accesses for one DMA channel. A start pulse hands it a source address, a destination address, a byte count, the configured source and destination access sizes and an auto-align enable. It then issues read requests and write requests, one at a time, to a bus interface. Each request carries an address and a size. The sequencer holds the request until the interface returns a one-cycle acknowledge.

After every acknowledged read, the sequencer issues destination writes that together cover exactly the bytes just read. It then moves on to the next read, until the byte count is used up. Auto-align is in effect when it is enabled and the source size is wider than the destination size. In that case the reads are aligned to the source size: narrow leading reads bring the address up to the natural boundary, full-width reads follow, and narrow reads finish any tail. Because of this, the count may step past an intermediate value rather than land on it.

The bus protocol, the data path and arbitration belong to other blocks.

Top module: `aas_sequencer`

## Requirements
- R1: While reset is held, and after it is released, no request is raised, `busy` is low and `done` is low until a start is accepted.
- R2: Size codes are 00 = 4 bytes, 01 = 1 byte and 10 = 2 bytes. A configured size of 11 is treated as 1 byte, and `acc_size` never shows 11 while a request is raised.
- R3: When auto-align is on and the source size is wider than the destination size, each read takes the largest of 4, 2 or 1 bytes that meets three limits: it does not exceed the source size, it does not exceed the remaining count, and the source address is a multiple of it. Example: source 0x0001, count 0xF0, 4-byte source and 1-byte destination give a 1-byte read at 0x0001, a 2-byte read at 0x0002, 4-byte reads from 0x0004 to 0x00EC, and a 1-byte read at 0x00F0.
- R4: In every other case, each read uses the configured source size, reduced to the largest of 4, 2 or 1 that does not exceed the remaining count. Address alignment is not considered.
- R5: After each acknowledged read, writes follow, and their sizes sum to exactly the bytes read before the next read is issued. The destination address advances by each write's size.
- R6: Each write takes the largest of 4, 2 or 1 bytes that meets three limits: it does not exceed the destination size, it does not exceed the bytes still unwritten from the current read, and the destination address is a multiple of it.
- R7: The source address advances by the size of each acknowledged read.
- R8: The count drops by the size of each acknowledged write. The cycle after the write that brings the count to zero, `done` is high for one cycle and `busy` is low. A start with a count of zero gives that `done` pulse the next cycle, with no accesses.
- R9: A request keeps its kind, address and size until it is acknowledged, and a read request and a write request are never raised together.
- R10: A start while `busy` is high is ignored, and the access sequence already in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| src_addr | input | AW | First source byte address |
| dst_addr | input | AW | First destination byte address |
| byte_count | input | CW | Number of bytes to move |
| src_size | input | 2 | Configured source size code |
| dst_size | input | 2 | Configured destination size code |
| auto_align | input | 1 | Auto-align enable |
| ack | input | 1 | One-cycle acknowledge of the current request |
| rd_req | output | 1 | Read request |
| wr_req | output | 1 | Write request |
| acc_addr | output | AW | Address of the current request |
| acc_size | output | 2 | Size code of the current request |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong internal value shows up at the ports on the very next request.

- A bad source or destination address register gives a wrong `acc_addr` on the next access of that kind.
- A wrong size choice shows in `acc_size`. It also shifts every later address, so the error grows rather than hides.
- A remaining count or a per-read chunk counter that is off changes the number of writes after a read, or moves the `done` pulse by at least one access.

The bench compares every request in order against a model built from the requirements. It also checks `done` in the exact cycle after the final acknowledge, so any of these faults is caught within one handshake.

// File: rtl/aas_pkg.sv
// Package: shared size codes, FSM states and size conversion helpers
// for the auto-align access sequencer.
package aas_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } aas_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } aas_state_e;

    // Converts a size code to a byte count; the reserved code maps to one byte.
    function automatic logic [2:0] code_to_bytes(input logic [1:0] code);
        case (code)
            SZ_LONG: code_to_bytes = 3'd4;
            SZ_WORD: code_to_bytes = 3'd2;
            default: code_to_bytes = 3'd1;
        endcase
    endfunction

    // Converts a byte count of 1, 2 or 4 back to its size code.
    function automatic logic [1:0] bytes_to_code(input logic [2:0] nbytes);
        case (nbytes)
            3'd4:    bytes_to_code = SZ_LONG;
            3'd2:    bytes_to_code = SZ_WORD;
            default: bytes_to_code = SZ_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/aas_size_pick.sv
// Module: aas_size_pick
// Chooses the size of one access as the largest of 4, 2 or 1 bytes that
// fits under a size cap and under a remaining byte count. When align_en is
// set, the address must also be a multiple of the chosen size.
// Assumes cap_bytes is 1, 2 or 4 and remain is non-zero whenever the
// result is used.
module aas_size_pick #(
    parameter int RW = 16
) (
    input  logic [1:0]    addr_lo,
    input  logic [2:0]    cap_bytes,
    input  logic [RW-1:0] remain,
    input  logic          align_en,
    output logic [2:0]    pick_bytes
);

    logic fits4;
    logic fits2;

    // Tests each candidate size against the cap, the remaining count and the alignment.
    always_comb begin
        fits4 = (cap_bytes >= 3'd4) && (remain >= RW'(4))
                && (!align_en || (addr_lo == 2'b00));
        fits2 = (cap_bytes >= 3'd2) && (remain >= RW'(2))
                && (!align_en || !addr_lo[0]);
    end

    // Picks the widest candidate that fits.
    always_comb begin
        if (fits4)      pick_bytes = 3'd4;
        else if (fits2) pick_bytes = 3'd2;
        else            pick_bytes = 3'd1;
    end

endmodule

// File: rtl/aas_addr_track.sv
// Module: aas_addr_track
// Holds the running source address, destination address, remaining byte
// count and the bytes still unwritten from the current read.
// Assumes rd_step and wr_step are never high together and that no step
// moves a counter below zero.
module aas_addr_track #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_src,
    input  logic [AW-1:0] load_dst,
    input  logic [CW-1:0] load_cnt,
    input  logic          rd_step,
    input  logic [2:0]    rd_bytes,
    input  logic          wr_step,
    input  logic [2:0]    wr_bytes,
    output logic [AW-1:0] src_a,
    output logic [AW-1:0] dst_a,
    output logic [CW-1:0] remain,
    output logic [2:0]    chunk
);

    // Loads the channel setup, or applies a read step or a write step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_a  <= '0;
            dst_a  <= '0;
            remain <= '0;
            chunk  <= '0;
        end else if (load) begin
            src_a  <= load_src;
            dst_a  <= load_dst;
            remain <= load_cnt;
            chunk  <= '0;
        end else if (rd_step) begin
            src_a  <= src_a + AW'(rd_bytes);
            chunk  <= rd_bytes;
        end else if (wr_step) begin
            dst_a  <= dst_a + AW'(wr_bytes);
            remain <= remain - CW'(wr_bytes);
            chunk  <= chunk - wr_bytes;
        end
    end

endmodule

// File: rtl/aas_sequencer.sv
// Module: aas_sequencer (top)
// Issues the read and write requests of one DMA channel.
// After each read it issues writes that together cover the bytes read.
// With auto-align on and the source wider than the destination, reads are
// aligned to the source size. Writes are always sized by the destination
// address alignment.
// Assumes ack is high for one cycle and only while a request is raised.
module aas_sequencer
    import aas_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] byte_count,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          auto_align,
    input  logic          ack,
    output logic          rd_req,
    output logic          wr_req,
    output logic [AW-1:0] acc_addr,
    output logic [1:0]    acc_size,
    output logic          busy,
    output logic          done
);

    localparam int CHUNK_W = 3;

    aas_state_e    state_q;
    aas_state_e    state_d;
    logic [2:0]    src_bytes_q;
    logic [2:0]    dst_bytes_q;
    logic          align_q;
    logic          done_q;
    logic          load;
    logic          zero_start;
    logic          rd_step;
    logic          wr_step;
    logic [AW-1:0] src_a;
    logic [AW-1:0] dst_a;
    logic [CW-1:0] remain;
    logic [2:0]    chunk;
    logic [2:0]    rd_bytes;
    logic [2:0]    wr_bytes;

    // Decodes the start and the handshake events.
    always_comb begin
        load       = (state_q == ST_IDLE) && start && (byte_count != '0);
        zero_start = (state_q == ST_IDLE) && start && (byte_count == '0);
        rd_step    = (state_q == ST_READ) && ack;
        wr_step    = (state_q == ST_WRITE) && ack;
    end

    // Next-state logic: read, then writes until the read is covered, then
    // finish once the count is used up.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (load) state_d = ST_READ;
            ST_READ:  if (ack) state_d = ST_WRITE;
            ST_WRITE: begin
                if (ack) begin
                    if (remain == CW'(wr_bytes))  state_d = ST_IDLE;
                    else if (chunk == wr_bytes)   state_d = ST_READ;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and the one-cycle completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= zero_start || (wr_step && (remain == CW'(wr_bytes)));
        end
    end

    // Latches the size configuration and the auto-align decision at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_bytes_q <= 3'd1;
            dst_bytes_q <= 3'd1;
            align_q     <= 1'b0;
        end else if (load) begin
            src_bytes_q <= code_to_bytes(src_size);
            dst_bytes_q <= code_to_bytes(dst_size);
            align_q     <= auto_align
                           && (code_to_bytes(src_size) > code_to_bytes(dst_size));
        end
    end

    aas_addr_track #(
        .AW(AW),
        .CW(CW)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_src (src_addr),
        .load_dst (dst_addr),
        .load_cnt (byte_count),
        .rd_step  (rd_step),
        .rd_bytes (rd_bytes),
        .wr_step  (wr_step),
        .wr_bytes (wr_bytes),
        .src_a    (src_a),
        .dst_a    (dst_a),
        .remain   (remain),
        .chunk    (chunk)
    );

    aas_size_pick #(
        .RW(CW)
    ) rd_pick_i (
        .addr_lo    (src_a[1:0]),
        .cap_bytes  (src_bytes_q),
        .remain     (remain),
        .align_en   (align_q),
        .pick_bytes (rd_bytes)
    );

    aas_size_pick #(
        .RW(CHUNK_W)
    ) wr_pick_i (
        .addr_lo    (dst_a[1:0]),
        .cap_bytes  (dst_bytes_q),
        .remain     (chunk),
        .align_en   (1'b1),
        .pick_bytes (wr_bytes)
    );

    // Drives the request outputs from the state and the chosen size.
    always_comb begin
        rd_req   = (state_q == ST_READ);
        wr_req   = (state_q == ST_WRITE);
        acc_addr = (state_q == ST_WRITE) ? dst_a : src_a;
        acc_size = bytes_to_code((state_q == ST_WRITE) ? wr_bytes : rd_bytes);
        busy     = (state_q != ST_IDLE);
        done     = done_q;
    end

endmodule

// File: rtl/aas_sequencer_chk.sv
// Module: aas_sequencer_chk
// Port-level protocol properties of the sequencer, bound to the top.
module aas_sequencer_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          rd_req,
    input logic          wr_req,
    input logic [AW-1:0] acc_addr,
    input logic [1:0]    acc_size,
    input logic          busy,
    input logic          done
);

    // R9
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ack) |=> (rd_req && $stable(acc_addr) && $stable(acc_size)));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !ack) |=> (wr_req && $stable(acc_addr) && $stable(acc_size)));

    // R2
    no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> (acc_size != 2'b11));

    // R6
    wr_long_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_size == 2'b00) |-> (acc_addr[1:0] == 2'b00));

    // R6
    wr_word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && acc_size == 2'b10) |-> !acc_addr[0]);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |-> busy);

endmodule

bind aas_sequencer aas_sequencer_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .busy     (busy),
    .done     (done)
);

// File: tb/aas_sequencer_tb_top.sv
// Bench: directed and seeded random channels, each request compared in
// order against a model built from the requirements.
module aas_sequencer_tb_top;

    localparam int AW = 32;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic [1:0]    src_size = 2'b00;
    logic [1:0]    dst_size = 2'b00;
    logic          auto_align = 1'b0;
    logic          ack = 1'b0;
    logic          rd_req;
    logic          wr_req;
    logic [AW-1:0] acc_addr;
    logic [1:0]    acc_size;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    bit stray = 1'b0;

    always #2 clk = ~clk;

    aas_sequencer #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .dst_addr(dst_addr), .byte_count(byte_count), .src_size(src_size),
        .dst_size(dst_size), .auto_align(auto_align), .ack(ack),
        .rd_req(rd_req), .wr_req(wr_req), .acc_addr(acc_addr),
        .acc_size(acc_size), .busy(busy), .done(done)
    );

    function automatic int cap_of(input logic [1:0] code);
        return (code == 2'b00) ? 4 : (code == 2'b10) ? 2 : 1;
    endfunction

    function automatic logic [1:0] code_of(input int n);
        return (n == 4) ? 2'b00 : (n == 2) ? 2'b10 : 2'b01;
    endfunction

    // Largest of 4, 2, 1 under cap and remaining, aligned when requested (R3, R4, R6).
    function automatic int pick(input longint a, input int cap, input longint rem, input bit al);
        if (cap >= 4 && rem >= 4 && (!al || (a % 4) == 0)) return 4;
        if (cap >= 2 && rem >= 2 && (!al || (a % 2) == 0)) return 2;
        return 1;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Waits for a request, compares it, then acknowledges it.
    task automatic take_req(input bit exp_wr, input longint exp_addr, input int exp_n,
                            input string req);
        int guard = 0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        while (!rd_req && !wr_req && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check(wr_req == exp_wr && rd_req == !exp_wr, "R9 kind", {rd_req, wr_req}, {!exp_wr, exp_wr});
        check(acc_addr == AW'(exp_addr), {req, " addr"}, acc_addr, exp_addr);
        check(acc_size == code_of(exp_n), {req, " size"}, acc_size, code_of(exp_n));
        ack = 1'b1;
        if (stray) begin
            start    = 1'b1;          // R10: start while busy
            src_addr = 32'hDEAD_0000;
            byte_count = 24'd3;
        end
        @(negedge clk);
        ack = 1'b0;
        start = 1'b0;
        stray = 1'b0;
    endtask

    task automatic run_case(input longint sa, input longint da, input int cnt,
                            input logic [1:0] ss, input logic [1:0] ds, input bit aa,
                            input bit poke);
        longint s = sa;
        longint d = da;
        longint rem = cnt;
        bit al = aa && (cap_of(ss) > cap_of(ds));
        src_addr = AW'(sa); dst_addr = AW'(da); byte_count = CW'(cnt);
        src_size = ss; dst_size = ds; auto_align = aa;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cnt == 0) begin
            check(done && !busy && !rd_req, "R8 zero count", {done, busy, rd_req}, 3'b100);
            @(negedge clk);
            return;
        end
        stray = poke;
        while (rem > 0) begin
            int rn = pick(s, cap_of(ss), rem, al);
            int left = rn;
            take_req(1'b0, s, rn, al ? "R3 read" : "R4 read");
            s += rn;                                   // R7
            while (left > 0) begin
                int wn = pick(d, cap_of(ds), left, 1'b1);
                take_req(1'b1, d, wn, "R5 R6 write");
                d += wn; left -= wn; rem -= wn;
            end
        end
        check(done && !busy, "R8 done after last write", {done, busy}, 2'b10);
        @(negedge clk);
        check(!done, "R8 done one cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        start = 1'b1;                         // R1: start ignored under reset
        repeat (3) @(negedge clk);
        start = 1'b0;
        check(!rd_req && !wr_req && !busy && !done, "R1 in reset",
              {rd_req, wr_req, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !wr_req && !busy && !done, "R1 after reset",
              {rd_req, wr_req, busy, done}, 0);
        // R3 worked example
        run_case(64'h1, 64'h100, 'hF0, 2'b00, 2'b01, 1'b1, 1'b0);
        // R4 no auto-align, unaligned long reads, R10 stray start
        run_case(64'h3, 64'h201, 11, 2'b00, 2'b10, 1'b0, 1'b1);
        // R2 reserved codes act as a byte
        run_case(64'h5, 64'h7, 5, 2'b11, 2'b11, 1'b1, 1'b0);
        // R6 wide destination, narrow source
        run_case(64'h2, 64'h301, 9, 2'b10, 2'b00, 1'b1, 1'b0);
        // R8 zero count
        run_case(64'h0, 64'h0, 0, 2'b00, 2'b00, 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            run_case($urandom_range(0, 255), $urandom_range(0, 255),
                     $urandom_range(0, 40), 2'($urandom_range(0, 3)),
                     2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)));
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule